// File: doc/BRIEF.md
# Power-Controller Mailbox Command Sequencer

This block lets on-chip logic send one command at a time to a power-management microcontroller. The microcontroller is reached through three 32-bit mailbox registers: a message register, a response register and an argument register. A requester hands over an 8-bit message ID, a 32-bit argument and a flag that says whether a return value is wanted. The sequencer then runs the whole exchange by itself over a single-beat memory-mapped master port and reports the outcome.

An exchange runs in four steps. First the sequencer polls until the mailbox is free, which it takes to mean a nonzero response. It then clears the response, loads the argument and finally the message ID, and polls again for the answer. It turns the answer into a 3-bit status. When a return value was asked for and the command succeeded, it waits a settling time and reads the argument register back. The poll interval, the poll limit and the settling time are counted in microseconds, taken from a tick derived from the clock, so a test build can shrink them.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A request is taken when req_valid and req_ready are both high. req_ready is high only while no command is in progress, so a request offered during a command is not taken.
- R2: Before writing anything, the sequencer reads the response register (byte offset 0x980) until it reads nonzero. Between a zero read and the next read there are at least POLL_US microseconds (POLL_US*TICK_DIV cycles).
- R3: If POLL_LIMIT consecutive pre-command reads return zero, the command ends with status 4 (controller unreachable) and no write is made.
- R4: Once the mailbox is free, exactly three writes follow, in this order: 0 to the response register, the argument to the argument register (0x9BC), and the message ID zero-extended to the message register (0x538).
- R5: After the message write, the response register is polled again with the same interval. If POLL_LIMIT consecutive reads return zero, the command ends with status 5 (response timeout).
- R6: A nonzero response is decoded as follows: 0x01 gives status 0 (ok), 0xFC gives status 1 (busy) and 0xFE gives status 2 (invalid command). 0xFD, 0xFF and every other nonzero value give status 3 (I/O error).
- R7: On status 0 with return data requested, the sequencer waits at least SETTLE_US microseconds after the successful response read, then reads the argument register and returns that value on done_data. In all other cases the argument register is not read and done_data is 0.
- R8: The bus port carries one access at a time. bus_req, bus_we, bus_addr and bus_wdata stay stable from the start of an access until bus_ack.
- R9: done is a one-cycle pulse and done_status/done_data are valid with it. After reset, req_ready is 1, done is 0 and bus_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_msg | input | 8 | Message ID |
| req_arg | input | 32 | Argument value |
| req_want_data | input | 1 | Read back a return value on success |
| done | output | 1 | Completion pulse |
| done_status | output | 3 | 0 ok, 1 busy, 2 invalid, 3 I/O error, 4 unreachable, 5 response timeout |
| done_data | output | 32 | Return value, 0 when none |
| bus_req | output | 1 | Access request to the mailbox window |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte offset inside the controller window |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
A scripted responder sets how many zero reads it gives before and after the message write, and which result code and return value it supplies. Varying the pre-command zero count between POLL_LIMIT-1 and POLL_LIMIT tells a late-but-ready mailbox apart from an unreachable one. The same split after the message write tells a slow answer apart from a response timeout. Each result code is tried with a return value requested, which separates the decode classes from the settle-and-read path. A request offered mid-command shows that only one command is ever written.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef logic [31:0] mbx_word_t;

  // mailbox register byte offsets inside the controller window
  localparam mbx_word_t MBX_OFS_MSG = 32'h0000_0538;
  localparam mbx_word_t MBX_OFS_RSP = 32'h0000_0980;
  localparam mbx_word_t MBX_OFS_ARG = 32'h0000_09BC;

  // result codes returned by the microcontroller
  localparam mbx_word_t RC_OK      = 32'h0000_0001;
  localparam mbx_word_t RC_BUSY    = 32'h0000_00FC;
  localparam mbx_word_t RC_PREREQ  = 32'h0000_00FD;
  localparam mbx_word_t RC_UNKNOWN = 32'h0000_00FE;
  localparam mbx_word_t RC_FAILED  = 32'h0000_00FF;

  typedef enum logic [2:0] {
    MS_OK      = 3'd0,
    MS_BUSY    = 3'd1,
    MS_INVAL   = 3'd2,
    MS_IO      = 3'd3,
    MS_NOREACH = 3'd4,
    MS_RSP_TMO = 3'd5
  } mbx_status_e;

  typedef enum logic [3:0] {
    FS_IDLE,
    FS_PRE_RD,
    FS_PRE_WT,
    FS_CLR,
    FS_ARG,
    FS_MSG,
    FS_POST_RD,
    FS_POST_WT,
    FS_SETTLE,
    FS_DATA_RD,
    FS_DONE
  } mbx_state_e;

  function automatic mbx_status_e decode_rsp(input mbx_word_t rsp);
    case (rsp)
      RC_OK:                 return MS_OK;
      RC_BUSY:               return MS_BUSY;
      RC_UNKNOWN:            return MS_INVAL;
      RC_PREREQ, RC_FAILED:  return MS_IO;
      default:               return MS_IO;
    endcase
  endfunction

  function automatic logic state_is_access(input mbx_state_e s);
    return (s == FS_PRE_RD) || (s == FS_CLR) || (s == FS_ARG) ||
           (s == FS_MSG) || (s == FS_POST_RD) || (s == FS_DATA_RD);
  endfunction

  function automatic logic state_is_write(input mbx_state_e s);
    return (s == FS_CLR) || (s == FS_ARG) || (s == FS_MSG);
  endfunction

  function automatic mbx_word_t state_offset(input mbx_state_e s);
    case (s)
      FS_ARG, FS_DATA_RD: return MBX_OFS_ARG;
      FS_MSG:             return MBX_OFS_MSG;
      default:            return MBX_OFS_RSP;
    endcase
  endfunction

endpackage

// File: rtl/mbox_us_tick.sv
module mbox_us_tick #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_us,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  assign expired = tick && (remain == CNT_W'(1)) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          remain <= '0;
    else if (start)                      remain <= load_us;
    else if (tick && (remain != '0))     remain <= remain - 1'b1;
  end
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int TICK_DIV   = 100,
  parameter int POLL_US    = 100,
  parameter int POLL_LIMIT = 20000,
  parameter int SETTLE_US  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_msg,
  input  logic [31:0]       req_arg,
  input  logic              req_want_data,
  output logic              done,
  output logic [2:0]        done_status,
  output logic [31:0]       done_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);
  localparam int MAX_US = (POLL_US > SETTLE_US) ? POLL_US : SETTLE_US;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  mbx_state_e        state;
  logic [7:0]        msg_q;
  logic [31:0]       arg_q;
  logic              want_q;
  logic [POLL_W-1:0] poll_cnt;
  mbx_status_e       status_q;
  logic [31:0]       data_q;

  // named internal events
  logic            accept;
  logic            access_done;
  logic            rsp_zero;
  logic            poll_last;
  logic            timer_start;
  logic [US_W-1:0] timer_load;
  logic            us_tick;
  logic            wait_over;
  mbx_status_e     rsp_class;

  assign accept      = req_valid && req_ready;
  assign access_done = bus_req && bus_ack;
  assign rsp_zero    = (bus_rdata == '0);
  assign poll_last   = (poll_cnt == POLL_W'(POLL_LIMIT - 1));
  assign rsp_class   = decode_rsp(bus_rdata);

  always_comb begin
    timer_start = 1'b0;
    timer_load  = US_W'(POLL_US);
    if (access_done && rsp_zero && !poll_last &&
        ((state == FS_PRE_RD) || (state == FS_POST_RD))) begin
      timer_start = 1'b1;
    end else if (access_done && (state == FS_POST_RD) && !rsp_zero &&
                 (rsp_class == MS_OK) && want_q) begin
      timer_start = 1'b1;
      timer_load  = US_W'(SETTLE_US);
    end
  end

  mbox_us_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (timer_start),
    .tick  (us_tick)
  );

  mbox_wait_timer #(.CNT_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (timer_start),
    .load_us (timer_load),
    .tick    (us_tick),
    .expired (wait_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      msg_q    <= '0;
      arg_q    <= '0;
      want_q   <= 1'b0;
      poll_cnt <= '0;
      status_q <= MS_OK;
      data_q   <= '0;
    end else begin
      case (state)
        FS_IDLE: if (accept) begin
          msg_q    <= req_msg;
          arg_q    <= req_arg;
          want_q   <= req_want_data;
          poll_cnt <= '0;
          data_q   <= '0;
          state    <= FS_PRE_RD;
        end
        FS_PRE_RD: if (access_done) begin
          if (!rsp_zero) begin
            poll_cnt <= '0;
            state    <= FS_CLR;
          end else if (poll_last) begin
            status_q <= MS_NOREACH;
            state    <= FS_DONE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            state    <= FS_PRE_WT;
          end
        end
        FS_PRE_WT:  if (wait_over)   state <= FS_PRE_RD;
        FS_CLR:     if (access_done) state <= FS_ARG;
        FS_ARG:     if (access_done) state <= FS_MSG;
        FS_MSG: if (access_done) begin
          poll_cnt <= '0;
          state    <= FS_POST_RD;
        end
        FS_POST_RD: if (access_done) begin
          if (!rsp_zero) begin
            status_q <= rsp_class;
            state    <= ((rsp_class == MS_OK) && want_q) ? FS_SETTLE : FS_DONE;
          end else if (poll_last) begin
            status_q <= MS_RSP_TMO;
            state    <= FS_DONE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            state    <= FS_POST_WT;
          end
        end
        FS_POST_WT: if (wait_over)   state <= FS_POST_RD;
        FS_SETTLE:  if (wait_over)   state <= FS_DATA_RD;
        FS_DATA_RD: if (access_done) begin
          data_q <= bus_rdata;
          state  <= FS_DONE;
        end
        FS_DONE:    state <= FS_IDLE;
        default:    state <= FS_IDLE;
      endcase
    end
  end

  // bus port: fields derived from the held state, so stable until ack
  always_comb begin
    bus_req   = state_is_access(state);
    bus_we    = state_is_write(state);
    bus_addr  = ADDR_W'(state_offset(state));
    bus_wdata = '0;
    if (state == FS_ARG)      bus_wdata = arg_q;
    else if (state == FS_MSG) bus_wdata = {24'd0, msg_q};
  end

  assign req_ready   = (state == FS_IDLE);
  assign done        = (state == FS_DONE);
  assign done_status = status_q;
  assign done_data   = data_q;

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              done,
  input logic [2:0]        done_status,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack
);
  localparam logic [ADDR_W-1:0] A_MSG = ADDR_W'(MBX_OFS_MSG);
  localparam logic [ADDR_W-1:0] A_RSP = ADDR_W'(MBX_OFS_RSP);
  localparam logic [ADDR_W-1:0] A_ARG = ADDR_W'(MBX_OFS_ARG);

  logic              wr_done;
  logic [ADDR_W-1:0] last_wr;

  assign wr_done = bus_req && bus_ack && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_wr <= '0;
    else if (wr_done) last_wr <= bus_addr;
  end

  assert_refuse_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_clear_writes_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_RSP) |-> (bus_wdata == '0));

  assert_arg_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && bus_addr == A_ARG) |-> (last_wr == A_RSP));

  assert_msg_after_arg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && bus_addr == A_MSG) |-> (last_wr == A_ARG));

  assert_status_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status <= 3'd5));

  assert_bus_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .accept      (accept),
  .done        (done),
  .done_status (done_status),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ack     (bus_ack)
);

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
  localparam int ADDR_W = 12;
  localparam int TDIV   = 2;
  localparam int PUS    = 3;
  localparam int PLIM   = 4;
  localparam int SUS    = 5;
  localparam logic [ADDR_W-1:0] O_MSG = 12'h538;
  localparam logic [ADDR_W-1:0] O_RSP = 12'h980;
  localparam logic [ADDR_W-1:0] O_ARG = 12'h9BC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_msg = '0;
  logic [31:0] req_arg = '0;
  logic req_want_data = 1'b0;
  logic done;
  logic [2:0] done_status;
  logic [31:0] done_data;
  logic bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  mbox_cmd_seq #(.ADDR_W(ADDR_W), .TICK_DIV(TDIV), .POLL_US(PUS),
                 .POLL_LIMIT(PLIM), .SETTLE_US(SUS)) i_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_msg(req_msg), .req_arg(req_arg), .req_want_data(req_want_data),
    .done(done), .done_status(done_status), .done_data(done_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scripted responder state
  int pre_left, post_left, phase;
  logic [31:0] m_result, m_ret, arg_reg;
  int n_pre_rd, n_post_rd, n_arg_rd, n_wr;
  logic [ADDR_W-1:0] wr_a [0:15];
  logic [31:0] wr_d [0:15];
  int last_rsp_cyc, min_gap, ok_rsp_cyc, arg_rd_cyc;
  logic last_rsp_zero;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack = 1'b1;
      if (bus_we) begin
        if (n_wr < 16) begin wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; end
        n_wr++;
        if (bus_addr == O_ARG) arg_reg = bus_wdata;
        if (bus_addr == O_MSG) begin phase = 1; arg_reg = m_ret; end
      end else if (bus_addr == O_RSP) begin
        if (last_rsp_zero && (cyc - last_rsp_cyc) < min_gap) min_gap = cyc - last_rsp_cyc;
        if (phase == 0) begin
          n_pre_rd++;
          if (pre_left > 0) begin bus_rdata = 0; pre_left--; end
          else bus_rdata = 32'h1;
        end else begin
          n_post_rd++;
          if (post_left > 0) begin bus_rdata = 0; post_left--; end
          else begin bus_rdata = m_result; ok_rsp_cyc = cyc; end
        end
        last_rsp_zero = (bus_rdata == 0);
        last_rsp_cyc = cyc;
      end else if (bus_addr == O_ARG) begin
        n_arg_rd++;
        arg_rd_cyc = cyc;
        bus_rdata = arg_reg;
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // run one command; results in out_status/out_data
  logic [2:0] out_status;
  logic [31:0] out_data;

  task automatic run_cmd(input logic [7:0] msg, input logic [31:0] arg, input bit want,
                         input int pre, input int post, input logic [31:0] res,
                         input logic [31:0] ret);
    int wait_n;
    pre_left = pre; post_left = post; phase = 0;
    m_result = res; m_ret = ret; arg_reg = 32'h0;
    n_pre_rd = 0; n_post_rd = 0; n_arg_rd = 0; n_wr = 0;
    min_gap = 1 << 30; last_rsp_zero = 1'b0; ok_rsp_cyc = 0; arg_rd_cyc = 0;
    @(negedge clk);
    chk(req_ready, "R1 ready before request", req_ready, 1);
    req_msg = msg; req_arg = arg; req_want_data = want; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low after accept", req_ready, 0);
    wait_n = 0;
    while (!done && wait_n < 2000) begin @(negedge clk); wait_n++; end
    chk(done, "R9 done reached", done, 1);
    out_status = done_status; out_data = done_data;
    @(negedge clk);
    chk(!done, "R9 done single pulse", done, 0);
  endtask

  task automatic check_sequence(input logic [7:0] msg, input logic [31:0] arg);
    chk(n_wr == 3, "R4 write count", n_wr, 3);
    chk(wr_a[0] == O_RSP && wr_d[0] == 0, "R4 first write clears response", wr_a[0], O_RSP);
    chk(wr_a[1] == O_ARG && wr_d[1] == arg, "R4 second write argument", wr_d[1], arg);
    chk(wr_a[2] == O_MSG && wr_d[2] == {24'd0, msg}, "R4 third write message", wr_d[2], msg);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R9 reset ready", req_ready, 1);
    chk(done == 0, "R9 reset done", done, 0);
    chk(bus_req == 0, "R9 reset bus_req", bus_req, 0);
  endtask

  task automatic t_ok_nodata();
    run_cmd(8'h06, 32'h0, 1'b0, 0, 1, 32'h1, 32'h1234);
    check_sequence(8'h06, 32'h0);
    chk(out_status == 0, "R6 ok status", out_status, 0);
    chk(out_data == 0, "R7 no data when not requested", out_data, 0);
    chk(n_arg_rd == 0, "R7 no argument read", n_arg_rd, 0);
    chk(min_gap >= PUS * TDIV, "R5 post poll interval", min_gap, PUS * TDIV);
  endtask

  task automatic t_ok_data();
    run_cmd(8'h09, 32'hA5A5_0001, 1'b1, 0, 0, 32'h1, 32'hDEAD_BEEF);
    check_sequence(8'h09, 32'hA5A5_0001);
    chk(out_status == 0, "R6 ok status with data", out_status, 0);
    chk(out_data == 32'hDEAD_BEEF, "R7 return value", out_data, 32'hDEAD_BEEF);
    chk(n_arg_rd == 1, "R7 one argument read", n_arg_rd, 1);
    chk(arg_rd_cyc - ok_rsp_cyc >= SUS * TDIV, "R7 settle delay", arg_rd_cyc - ok_rsp_cyc, SUS * TDIV);
  endtask

  task automatic t_late_idle();
    run_cmd(8'h02, 32'h7, 1'b0, PLIM - 1, 0, 32'h1, 32'h0);
    chk(n_pre_rd == PLIM, "R2 pre reads until nonzero", n_pre_rd, PLIM);
    chk(min_gap >= PUS * TDIV, "R2 pre poll interval", min_gap, PUS * TDIV);
    chk(out_status == 0, "R2 late idle still succeeds", out_status, 0);
    check_sequence(8'h02, 32'h7);
  endtask

  task automatic t_unreachable();
    run_cmd(8'h02, 32'h7, 1'b1, PLIM, 0, 32'h1, 32'h55);
    chk(out_status == 4, "R3 unreachable status", out_status, 4);
    chk(n_pre_rd == PLIM, "R3 pre read count", n_pre_rd, PLIM);
    chk(n_wr == 0, "R3 no writes", n_wr, 0);
    chk(out_data == 0, "R7 no data on unreachable", out_data, 0);
  endtask

  task automatic t_post_slow();
    run_cmd(8'h08, 32'h3, 1'b0, 0, PLIM - 1, 32'h1, 32'h0);
    chk(out_status == 0, "R5 slow answer ok", out_status, 0);
    chk(n_post_rd == PLIM, "R5 post read count", n_post_rd, PLIM);
  endtask

  task automatic t_post_timeout();
    run_cmd(8'h08, 32'h3, 1'b1, 0, PLIM, 32'h1, 32'h99);
    chk(out_status == 5, "R5 response timeout status", out_status, 5);
    chk(n_post_rd == PLIM, "R5 timeout read count", n_post_rd, PLIM);
    chk(n_arg_rd == 0, "R7 no argument read on timeout", n_arg_rd, 0);
  endtask

  task automatic t_codes();
    logic [31:0] codes [0:4];
    logic [2:0] exp_st [0:4];
    codes[0] = 32'hFC; exp_st[0] = 3'd1;
    codes[1] = 32'hFE; exp_st[1] = 3'd2;
    codes[2] = 32'hFD; exp_st[2] = 3'd3;
    codes[3] = 32'hFF; exp_st[3] = 3'd3;
    codes[4] = 32'h55; exp_st[4] = 3'd3;
    for (int i = 0; i < 5; i++) begin
      run_cmd(8'h11, 32'h20 + i, 1'b1, 0, 0, codes[i], 32'hCAFE_0000 + i);
      chk(out_status == exp_st[i], "R6 code decode", out_status, exp_st[i]);
      chk(n_arg_rd == 0 && out_data == 0, "R7 no data on error", out_data, 0);
    end
  endtask

  task automatic t_busy_refuse();
    int wait_n;
    pre_left = 0; post_left = 2; phase = 0; m_result = 32'h1; m_ret = 0;
    n_pre_rd = 0; n_post_rd = 0; n_arg_rd = 0; n_wr = 0;
    min_gap = 1 << 30; last_rsp_zero = 1'b0;
    @(negedge clk);
    req_msg = 8'h31; req_arg = 32'h1; req_want_data = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_msg = 8'h77; req_arg = 32'h2;
    for (int i = 0; i < 6; i++) begin
      chk(!req_ready, "R1 ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 2000) begin @(negedge clk); wait_n++; end
    chk(done && done_status == 0, "R1 first command completes", done_status, 0);
    repeat (60) @(negedge clk);
    chk(n_wr == 3 && wr_d[2] == 32'h31, "R1 only one command written", n_wr, 3);
    chk(req_ready, "R1 idle again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ok_nodata();
    t_ok_data();
    t_late_idle();
    t_unreachable();
    t_post_slow();
    t_post_timeout();
    t_codes();
    t_busy_refuse();
    // R8 bus hold is checked by the bound checker across all of the above
    summary_and_end();
  end

  initial begin
    #(5 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary_and_end();
  end
endmodule